// File: doc/BRIEF.md
# Misaligned Access Bus Cycle Splitter

This block sits between a master that reads and writes bytes, 16-bit halfwords and 32-bit words at any byte address, and a peripheral register space made only of 16-bit locations at even addresses. In that space the byte at the even address is the high half of a location and the byte at the following odd address is the low half. The block takes one master request and turns it into one, two or three peripheral cycles, each either an 8-bit or a 16-bit access. For writes it places each byte on the lane it belongs to and raises a matching per-lane strobe. For reads it gathers the returned bytes into the master data word.

Both sides use a plain request/acknowledge handshake. The master request is latched when the block is idle. Each peripheral cycle is held until the peripheral acknowledges it. The master is acknowledged for one clock, in the clock after the last peripheral acknowledge. Master data is big-endian and right-justified: a byte uses bits 7:0, a halfword bits 15:0, and a word all 32 bits, with the byte at the lowest address most significant.

Every cycle is built by one rule: take a single byte when the current address is odd or only one byte remains, otherwise take a halfword. This rule gives a three-cycle byte, halfword, byte sequence for a word at an odd address. Addresses wrap modulo the address width.

Top module: `bus_splitter`

## Requirements
- R1: A byte request (m_size 00) at any address gives exactly one 8-bit peripheral cycle (p_size 0) at that address. p_be is 10 at an even address and 01 at an odd address.
- R2: A halfword request (m_size 01) at an even address gives exactly one 16-bit peripheral cycle (p_size 1) at that address with p_be 11.
- R3: A halfword request at an odd address gives two 8-bit cycles: first at the odd address (p_be 01), then at the next address (p_be 10).
- R4: A word request (m_size 10 or 11) at an even address gives two 16-bit cycles, at the address and then at the address plus 2.
- R5: A word request at an odd address gives three cycles in this order: 8-bit at the address, 16-bit at the address plus 1, 8-bit at the address plus 3.
- R6: Read data is assembled big-endian and right-justified on m_rdata. For every p_rdata, bits 15:8 are the even-address byte and bits 7:0 the odd-address byte. Master bits above the request size read as zero.
- R7: On a write, p_wdata carries the even-address byte in bits 15:8 and the odd-address byte in bits 7:0, and only on the lanes set in p_be. Lanes not set are zero, and p_wdata is zero on reads.
- R8: m_ack rises in the clock after the final p_ack and stays high for exactly one clock.
- R9: Changes to m_req, m_we, m_size, m_addr or m_wdata after a request has been accepted have no effect until m_ack has been given.
- R10: After reset, p_req and m_ack are low.
- R11: While p_req is high and p_ack is low, p_addr, p_size, p_be and p_wdata stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | 1 | Master request, sampled while idle |
| m_we | input | 1 | Master write (1) or read (0) |
| m_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| m_addr | input | AW | Master byte address |
| m_wdata | input | 32 | Master write data, right-justified, big-endian |
| m_ack | output | 1 | One-clock completion pulse |
| m_rdata | output | 32 | Assembled read data, valid with m_ack |
| p_req | output | 1 | Peripheral cycle request |
| p_we | output | 1 | Peripheral cycle is a write |
| p_size | output | 1 | 0 = 8-bit cycle, 1 = 16-bit cycle |
| p_addr | output | AW | Peripheral byte address |
| p_be | output | 2 | Lane strobes: bit 1 even-address lane, bit 0 odd-address lane |
| p_wdata | output | 16 | Peripheral write data |
| p_ack | input | 1 | Peripheral cycle complete |
| p_rdata | input | 16 | Peripheral read data |

## Verification
Two events can fall in the same clock. A peripheral acknowledge can arrive in the first clock of a cycle, so the sequence advances while a new address is still being presented. The final acknowledge also lands while the master is still holding m_req with altered fields. The bench provokes the first case with a peripheral model that draws wait states of zero to two clocks. It provokes the second by scrambling the master inputs after the first peripheral cycle and keeping m_req high until m_ack. Each case is judged by comparing every recorded peripheral cycle, the returned word, and the clock of m_ack against the sequence the bench computes from the original request alone.

// File: rtl/split_pkg.sv
// Package: shared encodings for the bus cycle splitter.
// Assumes master transfer sizes are coded 00 byte, 01 halfword, 1x word.
package split_pkg;

    localparam int MST_W = 32;   // master data width
    localparam int PER_W = 16;   // peripheral location width

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUSY = 2'b01,
        ST_DONE = 2'b10
    } split_state_e;

    // Number of bytes moved by a master request of the given size code.
    function automatic logic [2:0] xfer_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Master byte that holds transfer byte j of an nb-byte request (big-endian).
    function automatic logic [7:0] pick_byte(input logic [31:0] w,
                                             input logic [2:0] nb,
                                             input logic [2:0] j);
        logic [2:0] pos;
        pos = nb - 3'd1 - j;
        return w[{pos[1:0], 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/split_step_gen.sv
// Step generator: picks the size and lane strobes of the next peripheral cycle.
// Assumes remain is 1..4 whenever the result is used. Purely combinational.
module split_step_gen (
    input  logic       addr_lsb,
    input  logic [2:0] remain,
    output logic       step_half,
    output logic [2:0] step_n,
    output logic [1:0] step_be
);

    // Halfword only when aligned and at least two bytes are left.
    always_comb begin
        step_half = !addr_lsb && (remain >= 3'd2);
        step_n    = step_half ? 3'd2 : 3'd1;
        if (step_half)
            step_be = 2'b11;
        else if (addr_lsb)
            step_be = 2'b01;
        else
            step_be = 2'b10;
    end

endmodule

// File: rtl/split_wr_steer.sv
// Write steering: places the master bytes of the current cycle on their lanes.
// Assumes done + 1 < nb whenever step_half is set. Lanes not covered carry zero.
module split_wr_steer
    import split_pkg::*;
(
    input  logic             we,
    input  logic [MST_W-1:0] wdata,
    input  logic [2:0]       nb,
    input  logic [2:0]       done,
    input  logic             addr_lsb,
    input  logic             step_half,
    output logic [PER_W-1:0] p_wdata
);

    logic [7:0] first_b;
    logic [7:0] second_b;

    // Select the transfer bytes at positions done and done+1.
    always_comb begin
        first_b  = pick_byte(wdata, nb, done);
        second_b = pick_byte(wdata, nb, done + 3'd1);
    end

    // Drive only the lanes of the current cycle; reads drive nothing.
    always_comb begin
        p_wdata = '0;
        if (we) begin
            if (step_half)
                p_wdata = {first_b, second_b};
            else if (addr_lsb)
                p_wdata[7:0] = first_b;
            else
                p_wdata[15:8] = first_b;
        end
    end

endmodule

// File: rtl/split_rd_gather.sv
// Read gather: collects peripheral read bytes into the big-endian master word.
// Assumes clear comes at request acceptance and capture with each peripheral ack.
module split_rd_gather
    import split_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             capture,
    input  logic [PER_W-1:0] p_rdata,
    input  logic [2:0]       nb,
    input  logic [2:0]       done,
    input  logic             addr_lsb,
    input  logic             step_half,
    output logic [MST_W-1:0] acc
);

    localparam int NLANE = MST_W / 8;

    logic [7:0] first_b;
    logic [7:0] second_b;

    // Choose the returned lane that holds the first byte of this cycle.
    always_comb begin
        first_b  = (!step_half && addr_lsb) ? p_rdata[7:0] : p_rdata[15:8];
        second_b = p_rdata[7:0];
    end

    // Accumulate bytes into master positions; unused positions remain zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
        end else if (capture) begin
            for (int k = 0; k < NLANE; k++) begin
                if (3'(k) < nb) begin
                    if ((nb - 3'd1 - 3'(k)) == done)
                        acc[k*8 +: 8] <= first_b;
                    else if (step_half && ((nb - 3'd1 - 3'(k)) == done + 3'd1))
                        acc[k*8 +: 8] <= second_b;
                end
            end
        end
    end

endmodule

// File: rtl/bus_splitter.sv
// Top: splits byte/halfword/word master requests at any address into
// 8/16-bit cycles on a space of 16-bit even-addressed locations.
// Assumes the peripheral holds p_ack for a single clock per cycle and the
// master keeps its request until m_ack; inputs are only sampled while idle.
module bus_splitter
    import split_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_req,
    input  logic             m_we,
    input  logic [1:0]       m_size,
    input  logic [AW-1:0]    m_addr,
    input  logic [MST_W-1:0] m_wdata,
    output logic             m_ack,
    output logic [MST_W-1:0] m_rdata,
    output logic             p_req,
    output logic             p_we,
    output logic             p_size,
    output logic [AW-1:0]    p_addr,
    output logic [1:0]       p_be,
    output logic [PER_W-1:0] p_wdata,
    input  logic             p_ack,
    input  logic [PER_W-1:0] p_rdata
);

    localparam logic [AW-1:0] ONE_A = AW'(1);

    split_state_e     state;
    logic             lat_we;
    logic [2:0]       lat_nb;
    logic [MST_W-1:0] lat_wdata;
    logic [AW-1:0]    cur_addr;
    logic [2:0]       done_b;
    logic             step_half;
    logic [2:0]       step_n;
    logic [1:0]       step_be;
    logic [2:0]       remain;
    logic             accept;
    logic             step_ack;

    // Handshake qualifiers for the sequencer.
    always_comb begin
        remain   = lat_nb - done_b;
        accept   = (state == ST_IDLE) && m_req;
        step_ack = (state == ST_BUSY) && p_ack;
    end

    split_step_gen u_step (
        .addr_lsb  (cur_addr[0]),
        .remain    (remain),
        .step_half (step_half),
        .step_n    (step_n),
        .step_be   (step_be)
    );

    split_wr_steer u_steer (
        .we        (lat_we),
        .wdata     (lat_wdata),
        .nb        (lat_nb),
        .done      (done_b),
        .addr_lsb  (cur_addr[0]),
        .step_half (step_half),
        .p_wdata   (p_wdata)
    );

    split_rd_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (step_ack),
        .p_rdata   (p_rdata),
        .nb        (lat_nb),
        .done      (done_b),
        .addr_lsb  (cur_addr[0]),
        .step_half (step_half),
        .acc       (m_rdata)
    );

    // Sequencer: latch request, advance per peripheral ack, pulse completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_we    <= 1'b0;
            lat_nb    <= 3'd1;
            lat_wdata <= '0;
            cur_addr  <= '0;
            done_b    <= 3'd0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (m_req) begin
                        lat_we    <= m_we;
                        lat_nb    <= xfer_bytes(m_size);
                        lat_wdata <= m_wdata;
                        cur_addr  <= m_addr;
                        done_b    <= 3'd0;
                        state     <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (p_ack) begin
                        done_b   <= done_b + step_n;
                        cur_addr <= cur_addr + (step_half ? (ONE_A + ONE_A) : ONE_A);
                        if (done_b + step_n == lat_nb)
                            state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from sequencer state.
    always_comb begin
        p_req  = (state == ST_BUSY);
        p_we   = lat_we;
        p_size = step_half;
        p_addr = cur_addr;
        p_be   = step_be;
        m_ack  = (state == ST_DONE);
    end

    // R8: completion is a single-clock pulse.
    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |=> !m_ack);

    // R8: completion follows an acknowledged peripheral cycle by one clock.
    a_r8_ack_after_final: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_ack) |-> $past(p_req && p_ack));

    // R11: a waiting cycle keeps its address, lanes and data.
    a_r11_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && !p_ack) |=> (p_req && $stable(p_addr) && $stable(p_be)
                               && $stable(p_wdata) && $stable(p_size)));

    // R2: every 16-bit cycle is aligned and strobes both lanes.
    a_r2_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_size) |-> (!p_addr[0] && p_be == 2'b11));

    // R1: every 8-bit cycle strobes exactly the lane its address selects.
    a_r1_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && !p_size) |-> ($countones(p_be) == 1 && p_be[0] == p_addr[0]));

    // R7: lanes without a strobe carry zero on writes.
    a_r7_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_we) |-> ((p_be[1] || p_wdata[15:8] == 8'h00)
                             && (p_be[0] || p_wdata[7:0] == 8'h00)));

    // R9: no peripheral cycle starts out of a completion clock.
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |=> !p_req);

endmodule

// File: tb/test_bus_splitter.sv
// Bench: directed shapes plus seeded random requests against a model peripheral.
module test_bus_splitter;

    localparam int AW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            m_req = 1'b0;
    logic            m_we = 1'b0;
    logic [1:0]      m_size = 2'b00;
    logic [AW-1:0]   m_addr = '0;
    logic [31:0]     m_wdata = '0;
    logic            m_ack;
    logic [31:0]     m_rdata;
    logic            p_req;
    logic            p_we;
    logic            p_size;
    logic [AW-1:0]   p_addr;
    logic [1:0]      p_be;
    logic [15:0]     p_wdata;
    logic            p_ack = 1'b0;
    logic [15:0]     p_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_ack_cyc = 0;
    int wait_cnt = 0;
    int max_wait = 2;
    int obs_n = 0;
    bit in_step = 1'b0;
    logic [AW-1:0] obs_addr [0:7];
    logic          obs_half [0:7];
    logic [1:0]    obs_be   [0:7];
    logic [15:0]   obs_wd   [0:7];
    logic          obs_we   [0:7];
    logic [AW-1:0] st_addr;
    logic [1:0]    st_be;
    logic [15:0]   st_wd;

    bus_splitter #(.AW(AW)) i_bus_splitter (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_we(m_we), .m_size(m_size), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata),
        .p_req(p_req), .p_we(p_we), .p_size(p_size), .p_addr(p_addr),
        .p_be(p_be), .p_wdata(p_wdata), .p_ack(p_ack), .p_rdata(p_rdata)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        logic [15:0] t;
        t = 16'(a) * 16'd29 + 16'h3B;
        return t[7:0] ^ t[15:8];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Peripheral model: random wait states, records each acknowledged cycle.
    always @(negedge clk) begin
        if (rst_n && p_req) begin
            if (!in_step) begin
                in_step = 1'b1;
                st_addr = p_addr; st_be = p_be; st_wd = p_wdata;
            end
            if (wait_cnt > 0) begin
                wait_cnt--;
                p_ack = 1'b0;
            end else begin
                // R11: fields at acknowledge equal those at cycle start
                chk(st_addr == p_addr && st_be == p_be && st_wd == p_wdata, "R11",
                    "cycle held", {p_addr, p_be, 14'd0}, {st_addr, st_be, 14'd0});
                if (obs_n < 8) begin
                    obs_addr[obs_n] = p_addr; obs_half[obs_n] = p_size;
                    obs_be[obs_n] = p_be; obs_wd[obs_n] = p_wdata; obs_we[obs_n] = p_we;
                end
                obs_n++;
                p_ack = 1'b1;
                p_rdata = {mem_byte(p_addr & ~AW'(1)), mem_byte((p_addr & ~AW'(1)) + AW'(1))};
                last_ack_cyc = cyc;
                wait_cnt = $urandom_range(0, max_wait);
                in_step = 1'b0;
            end
        end else begin
            p_ack = 1'b0;
        end
    end

    task automatic run(input bit we, input logic [1:0] sz, input logic [AW-1:0] addr,
                       input logic [31:0] wd, input bit scramble);
        logic [AW-1:0] ea [0:3];
        logic          eh [0:3];
        logic [1:0]    eb [0:3];
        logic [15:0]   ew [0:3];
        logic [31:0]   erd;
        logic [AW-1:0] a;
        int nb, r, j, ne, t, ack_c;
        string tg;
        nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        if (nb == 1) tg = "R1";
        else if (nb == 2) tg = addr[0] ? "R3" : "R2";
        else tg = addr[0] ? "R5" : "R4";
        a = addr; r = nb; j = 0; ne = 0;
        while (r > 0) begin
            logic [7:0] b0, b1;
            b0 = wd[(nb-1-j)*8 +: 8];
            b1 = (j + 1 < nb) ? wd[(nb-2-j)*8 +: 8] : 8'h00;
            ea[ne] = a;
            eh[ne] = !a[0] && r >= 2;
            if (eh[ne]) begin eb[ne] = 2'b11; ew[ne] = {b0, b1}; end
            else if (a[0]) begin eb[ne] = 2'b01; ew[ne] = {8'h00, b0}; end
            else begin eb[ne] = 2'b10; ew[ne] = {b0, 8'h00}; end
            if (!we) ew[ne] = 16'h0000;
            j += eh[ne] ? 2 : 1; r -= eh[ne] ? 2 : 1;
            a = a + (eh[ne] ? AW'(2) : AW'(1));
            ne++;
        end
        erd = '0;
        for (int k = 0; k < nb; k++) erd[(nb-1-k)*8 +: 8] = mem_byte(addr + AW'(k));

        @(negedge clk);
        obs_n = 0;
        m_we = we; m_size = sz; m_addr = addr; m_wdata = wd; m_req = 1'b1;
        t = 0;
        do begin
            @(negedge clk);
            t++;
            if (scramble && obs_n >= 1) begin  // R9: fields change mid-sequence
                m_we = ~we; m_size = 2'($urandom); m_addr = AW'($urandom);
                m_wdata = $urandom;
            end
        end while (!m_ack && t < 2000);
        ack_c = cyc;
        m_req = 1'b0;
        if (t >= 2000) begin
            chk(1'b0, tg, "watchdog expired", 32'(t), 32'd2000);
            return;
        end
        chk(obs_n == ne, scramble ? "R9" : tg, "cycle count", 32'(obs_n), 32'(ne));
        for (int k = 0; k < ne && k < obs_n; k++) begin
            chk(obs_addr[k] == ea[k], tg, "cycle address", 32'(obs_addr[k]), 32'(ea[k]));
            chk(obs_half[k] == eh[k] && obs_be[k] == eb[k], tg, "cycle size/strobes",
                {obs_half[k], obs_be[k]}, {eh[k], eb[k]});
            chk(obs_we[k] == we, "R9", "cycle direction", 32'(obs_we[k]), 32'(we));
            chk(obs_wd[k] == ew[k], "R7", "write lanes", 32'(obs_wd[k]), 32'(ew[k]));
        end
        if (!we) chk(m_rdata == erd, "R6", "read word", m_rdata, erd);
        chk(ack_c == last_ack_cyc + 1, "R8", "ack timing", 32'(ack_c), 32'(last_ack_cyc + 1));
        @(negedge clk);
        chk(m_ack == 1'b0, "R8", "ack width", 32'(m_ack), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10: idle outputs during and after reset
        chk(p_req == 1'b0 && m_ack == 1'b0, "R10", "reset outputs", {p_req, m_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(p_req == 1'b0 && m_ack == 1'b0, "R10", "idle after reset", {p_req, m_ack}, 0);

        // Directed shapes, zero-wait peripheral first
        max_wait = 0;
        run(1'b0, 2'b00, 16'h1000, 32'h0, 1'b0);          // R1 even
        run(1'b1, 2'b00, 16'h1001, 32'h000000C3, 1'b0);   // R1 odd
        run(1'b1, 2'b01, 16'h2002, 32'h0000A1B2, 1'b0);   // R2
        run(1'b0, 2'b01, 16'h2003, 32'h0, 1'b0);          // R3
        run(1'b1, 2'b01, 16'h2005, 32'h00005566, 1'b0);   // R3
        run(1'b1, 2'b10, 16'h3004, 32'h11223344, 1'b0);   // R4
        run(1'b0, 2'b11, 16'h3008, 32'h0, 1'b0);          // R4 with code 11
        run(1'b1, 2'b10, 16'h4001, 32'hDEADBEEF, 1'b0);   // R5
        run(1'b0, 2'b10, 16'h4003, 32'h0, 1'b0);          // R5
        run(1'b0, 2'b10, 16'hFFFD, 32'h0, 1'b0);          // R5 across wrap
        max_wait = 2;
        run(1'b1, 2'b10, 16'h5007, 32'hCAFEF00D, 1'b1);   // R9 scrambled
        run(1'b0, 2'b10, 16'h5009, 32'h0, 1'b1);          // R9 scrambled

        for (int n = 0; n < 300; n++) begin
            max_wait = $urandom_range(0, 2);
            run(1'($urandom), 2'($urandom), AW'($urandom), $urandom, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Global watchdog: a hung run still reaches the summary as a failure.
    initial begin
        #(5 * 150000);
        chk(1'b0, "R8", "global watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule